// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Backup-Clock Failover

This block decides when the next DRAM row must be refreshed and which row it is. It serves a nibble-mode array built from either 256-row or 512-row parts; a static density pin picks the row count. It emits one refresh request per interval on a valid/ready handshake, with the row address alongside. A downstream sequencer performs the RAS/CAS cycle, arbitrating against normal traffic, and raises ready once it has taken the row.

While the system bus clock runs, the block counts `TERM_CYC` of its cycles per interval. The default is 300 cycles at 20 MHz, which is 15 us. When power fails, the bus clock disappears. A glitch-free selector outside the block then feeds the block's clock from the slow backup oscillator, whose period is at most 7.5 us. The block learns of this through the `power_fail` pin, which it synchronises into its own clock. In that mode it divides the clock by two, so it still issues one request about every 15 us. That rate stays inside the 15.6 us per row that the 512-row / 8 ms retention limit allows. The 256-row parts need 256 rows every 4 ms.

Back-pressure rules: `req_valid` stays high until a cycle in which `req_ready` is also high. `req_row` does not change while a request waits. One further expired interval is remembered as pending. A waiting request plus one pending is the most the block holds.

Top module: `refresh_scheduler`

## Requirements
- R1: During and right after reset, `req_valid` is 0, `req_row` is 0 and `on_backup` is 0.
- R2: In bus-clock mode, with `req_ready` held high, `req_valid` pulses for one cycle every `TERM_CYC` clocks.
- R3: `on_backup` takes the value of `power_fail` after two rising clock edges. It equals 1 in backup mode and 0 in bus-clock mode.
- R4: In backup mode, with `req_ready` held high, `req_valid` pulses once every second clock (clock divided by two).
- R5: In the cycle where `on_backup` changes value, no interval expires, and the interval count restarts from zero. The first interval in the new mode is therefore a full one.
- R6: While `req_valid` is 1 and `req_ready` is 0, `req_valid` stays 1 on the next cycle and `req_row` keeps its value.
- R7: `req_row` advances by exactly one after each cycle with `req_valid` and `req_ready` both high, and holds otherwise.
- R8: When `density` is 0 the row wraps from 255 to 0. When it is 1 the row wraps from 511 to 0. A row above the active limit wraps to 0 on its next advance.
- R9: Requests held are counted as waiting plus pending, saturating at two. An interval expiring while a request waits becomes pending, so `req_valid` stays 1 after the next handshake. Expirations beyond two held requests are dropped.
- R10: Switching clock source in either direction keeps the row counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock: bus clock normally, backup oscillator during power fail |
| rst_n | input | 1 | Asynchronous active-low reset |
| power_fail | input | 1 | Asynchronous power-fail indication, 1 = bus clock gone |
| density | input | 1 | 0 = 256-row parts, 1 = 512-row parts |
| req_ready | input | 1 | Sequencer accepts the current refresh row |
| req_valid | output | 1 | A refresh row is due |
| req_row | output | ROW_W | Row address to refresh |
| on_backup | output | 1 | Synchronised power-fail state, 1 = backup timing in use |

## Verification
The hard corners are the source switchover and back-pressure across several intervals. A design that does not restart the interval count at the switch fires an early, spurious request. A design that clears the row counter at the switch restarts refresh from row 0 and starves the upper rows.

Holding ready low over three intervals exposes a missing or unsaturated pending flag. Without the flag a row is skipped. Without saturation extra requests appear once ready returns.

Long runs in backup mode cross both wrap points. A design that wraps at the wrong bound, or that ignores the density pin, diverges on the first row past 255.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  typedef enum logic {SRC_BUS = 1'b0, SRC_BKUP = 1'b1} clk_src_e;

  function automatic int unsigned row_last(input logic dense, input int unsigned small_rows,
                                           input int unsigned large_rows);
    return dense ? (large_rows - 1) : (small_rows - 1);
  endfunction
endpackage

// File: rtl/refresh_pf_sync.sv
module refresh_pf_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], async_in};
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer
  import refresh_pkg::*;
#(
  parameter int unsigned TERM_CYC = 300,
  parameter int unsigned BKUP_DIV = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  clk_src_e src,
  output logic     tick
);
  localparam int unsigned MAXC  = (TERM_CYC > BKUP_DIV) ? TERM_CYC : BKUP_DIV;
  localparam int unsigned CNT_W = $clog2(MAXC);

  clk_src_e         src_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;
  logic             switched;

  assign last     = (src == SRC_BKUP) ? CNT_W'(BKUP_DIV - 1) : CNT_W'(TERM_CYC - 1);
  assign switched = (src != src_q);
  assign tick     = !switched && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= SRC_BUS;
      cnt   <= '0;
    end else begin
      src_q <= src;
      if (switched || tick) cnt <= '0;
      else                  cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/refresh_row_tracker.sv
module refresh_row_tracker
  import refresh_pkg::*;
#(
  parameter int unsigned ROW_W      = 9,
  parameter int unsigned SMALL_ROWS = 256,
  parameter int unsigned LARGE_ROWS = 512,
  parameter int unsigned MAX_HELD   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             dense,
  input  logic             ready,
  output logic             valid,
  output logic [ROW_W-1:0] row
);
  localparam int unsigned HW = $clog2(MAX_HELD + 2);

  logic [HW-1:0]    held;
  logic [HW-1:0]    held_sum;
  logic             fire;
  logic [ROW_W-1:0] lim;

  assign valid    = (held != '0);
  assign fire     = valid && ready;
  assign held_sum = held - HW'(fire) + HW'(tick);
  assign lim      = ROW_W'(row_last(dense, SMALL_ROWS, LARGE_ROWS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= '0;
      row  <= '0;
    end else begin
      held <= (held_sum > HW'(MAX_HELD)) ? HW'(MAX_HELD) : held_sum;
      if (fire) row <= (row >= lim) ? '0 : row + 1'b1;
    end
  end
endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler
  import refresh_pkg::*;
#(
  parameter int unsigned TERM_CYC    = 300,
  parameter int unsigned BKUP_DIV    = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SMALL_ROWS  = 256,
  parameter int unsigned LARGE_ROWS  = 512,
  parameter int unsigned ROW_W       = $clog2(LARGE_ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             power_fail,
  input  logic             density,
  input  logic             req_ready,
  output logic             req_valid,
  output logic [ROW_W-1:0] req_row,
  output logic             on_backup
);
  logic     pf_s;
  logic     tick;
  clk_src_e src;

  refresh_pf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(power_fail), .sync_out(pf_s)
  );

  assign src       = pf_s ? SRC_BKUP : SRC_BUS;
  assign on_backup = (src == SRC_BKUP);

  refresh_interval_timer #(.TERM_CYC(TERM_CYC), .BKUP_DIV(BKUP_DIV)) u_timer (
    .clk(clk), .rst_n(rst_n), .src(src), .tick(tick)
  );

  refresh_row_tracker #(
    .ROW_W(ROW_W), .SMALL_ROWS(SMALL_ROWS), .LARGE_ROWS(LARGE_ROWS), .MAX_HELD(2)
  ) u_rows (
    .clk(clk), .rst_n(rst_n), .tick(tick), .dense(density), .ready(req_ready),
    .valid(req_valid), .row(req_row)
  );
endmodule

// File: rtl/refresh_scheduler_chk.sv
module refresh_scheduler_chk #(
  parameter int unsigned SMALL_ROWS = 256,
  parameter int unsigned LARGE_ROWS = 512,
  parameter int unsigned ROW_W      = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             density,
  input logic             req_ready,
  input logic             req_valid,
  input logic [ROW_W-1:0] req_row
);
  logic [ROW_W-1:0] next_row;
  assign next_row = (req_row >= ROW_W'(density ? LARGE_ROWS - 1 : SMALL_ROWS - 1))
                    ? '0 : req_row + 1'b1;

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_row)));

  p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (req_row == $past(next_row)));

  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> $stable(req_row));

  p_wrap_small_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !density) |=> (req_row < ROW_W'(SMALL_ROWS)));
endmodule

bind refresh_scheduler refresh_scheduler_chk #(
  .SMALL_ROWS(SMALL_ROWS), .LARGE_ROWS(LARGE_ROWS), .ROW_W(ROW_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .density(density), .req_ready(req_ready),
  .req_valid(req_valid), .req_row(req_row)
);

// File: tb/refresh_scheduler_bench.sv
module refresh_scheduler_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TERM       = 300;
  localparam int RW         = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          power_fail = 1'b0;
  logic          density = 1'b0;
  logic          req_ready = 1'b0;
  logic          req_valid;
  logic [RW-1:0] req_row;
  logic          on_backup;

  int n_vec  = 0;
  int n_fail = 0;
  int cycle  = 0;
  int fires  = 0;
  string phase = "R1";

  // behavioural reference state
  int m_s1 = 0, m_mode = 0, m_mode_q = 0, m_cnt = 0, m_held = 0, m_row = 0;
  int pf_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  refresh_scheduler #(.TERM_CYC(TERM)) u_refresh_scheduler (
    .clk(clk), .rst_n(rst_n), .power_fail(power_fail), .density(density),
    .req_ready(req_ready), .req_valid(req_valid), .req_row(req_row), .on_backup(on_backup)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_mode = 0; m_mode_q = 0; m_cnt = 0; m_held = 0; m_row = 0;
    end else begin
      automatic int fire = (m_held > 0 && req_ready) ? 1 : 0;
      automatic int tick = 0;
      automatic int span = (m_mode != 0) ? 2 : TERM;
      automatic int top  = density ? 511 : 255;
      cycle++;
      if (m_mode != m_mode_q) m_cnt = 0;
      else if (m_cnt == span - 1) begin tick = 1; m_cnt = 0; end
      else m_cnt++;
      m_held = m_held - fire + tick;
      if (m_held > 2) m_held = 2;
      if (fire != 0) begin
        fires++;
        m_row = (m_row >= top) ? 0 : m_row + 1;
      end
      m_mode_q = m_mode;
      m_mode   = m_s1;
      m_s1     = power_fail;
    end
  end

  task automatic compare();
    automatic int ev = (m_held > 0) ? 1 : 0;
    n_vec++;
    if (req_valid !== ev[0] || req_row !== RW'(m_row) || on_backup !== m_mode[0]) begin
      n_fail++;
      $display("FAIL %s cycle %0d: valid=%0b/%0b row=%0d/%0d backup=%0b/%0b (actual/expected)",
               phase, cycle, req_valid, ev[0], req_row, m_row, on_backup, m_mode[0]);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    int f0;
    phase = "R1 reset";
    run(4);
    @(negedge clk); rst_n = 1'b1; compare();
    run(2);

    phase = "R2 R7 bus-clock cadence";
    req_ready = 1'b1;
    f0 = fires;
    run(1200);
    check_int("R2 requests in 1200 bus cycles", fires - f0, 4);

    phase = "R6 R9 back-pressure and pending";
    req_ready = 1'b0;
    run(950);
    req_ready = 1'b1;
    f0 = fires;
    run(4);
    check_int("R9 held requests drained (saturated at two)", fires - f0, 2);

    phase = "R3 R5 R10 switch to backup";
    power_fail = 1'b1;
    run(6);
    phase = "R4 R8 backup cadence, small wrap";
    f0 = fires;
    run(600);
    check_int("R4 requests in 600 backup cycles", fires - f0, 300);

    phase = "R8 large-density wrap";
    density = 1'b1;
    run(1200);

    phase = "R6 R9 toggled ready in backup";
    for (int k = 0; k < 40; k++) begin
      req_ready = (k % 3 == 0);
      run(3);
    end
    req_ready = 1'b1;

    phase = "R8 density drop above small limit";
    run(300);
    density = 1'b0;
    run(20);

    phase = "R5 R10 return to bus clock";
    power_fail = 1'b0;
    run(700);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule